// File: doc/BRIEF.md
# Memory-Card Host Interrupt Request Router

This block keeps the pending-event register and the event-blocking register of a memory-card host controller and turns them into one processor interrupt line and two DMA request lines. The data and command engines raise single-cycle event pulses, and each pulse sets its own sticky pending bit. Three register-side actions clear bits again: a read of the receive data port, a write of the transmit data port, and a clock-start command. A clock-stop command sets the clock-off bit.

When the controller works in DMA mode, the receive-service and transmit-service bits no longer reach the processor line. Each drives its own DMA request output instead. The outputs are formed combinationally from the stored bits and the DMA-mode level, so they change in the cycle after the clock edge that updates a register.

The block holds no state machine. Its only states are the two stored 13-bit vectors.

Top module: `mmc_irq_router`

## Requirements
- R1: A pulse on `evt_set_i[k]` sets pending bit k at the next clock edge. The bit then stays set until a clear named in R6 or R7 removes it, or until reset. Bit meanings: 0 data done, 1 programming done, 2 command end, 3 stop command, 4 clock off, 5 receive service, 6 transmit service, 7 read timeout, 8 data error, 9 response error, 10 read stalled, 11 card interrupt, 12 card acknowledge.
- R2: A mask write stores `mask_wdata_i[12:0]` at the next edge. Bits 31 to 13 of the write data have no effect.
- R3: When `dma_mode_i` is low, `cpu_irq_o` is high exactly when some pending bit is set whose mask bit is clear. A set mask bit blocks its source.
- R4: When `dma_mode_i` is high, pending bits 5 and 6 are treated as masked for `cpu_irq_o`. The other bits still follow R3.
- R5: When `dma_mode_i` is high, `rx_dma_req_o` equals pending bit 5 and `tx_dma_req_o` equals pending bit 6. When it is low, both outputs are low.
- R6: `clk_stop_i` sets bit 4 and `clk_start_i` clears it. If both arrive in the same cycle, the bit ends up set.
- R7: `rx_port_rd_i` clears bit 5 and `tx_port_wr_i` clears bit 6. An event pulse for the same bit in the same cycle wins, and the bit stays set.
- R8: Reset clears the pending and mask registers, so all three request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set_i | input | 13 | Event pulses, one per pending bit |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 32 | Mask write data |
| dma_mode_i | input | 1 | DMA mode level from the command control word |
| clk_start_i | input | 1 | Clock-start command strobe |
| clk_stop_i | input | 1 | Clock-stop command strobe |
| rx_port_rd_i | input | 1 | Receive data port read strobe |
| tx_port_wr_i | input | 1 | Transmit data port write strobe |
| cpu_irq_o | output | 1 | Processor interrupt request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| req_o | output | 13 | Pending register readback |
| mask_o | output | 13 | Mask register readback |

## Verification
The assertions treat every strobe and event input as sampled at each rising edge, with no meaning carried over between cycles. They treat `dma_mode_i` as a level that may change at any edge, because every output check is made in the same cycle against the current mode. The stimulus changes inputs only on falling edges and drops every strobe after one cycle. It drives simultaneous set and clear only in the cases where R6 and R7 define the winner.

// File: rtl/mmc_irq_router_pkg.sv
package mmc_irq_router_pkg;
    localparam int unsigned SRC_N      = 13;
    localparam int unsigned BUS_W      = 32;
    localparam int unsigned B_CLK_OFF  = 4;
    localparam int unsigned B_RX_SERV  = 5;
    localparam int unsigned B_TX_SERV  = 6;
    typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/mmc_irq_pend.sv
module mmc_irq_pend #(
    parameter int unsigned W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    // One sticky cell per source; a set beats a clear in the same cycle.
    for (genvar g = 0; g < W; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_o[g] <= 1'b0;
            else if (set_i[g])
                q_o[g] <= 1'b1;
            else if (clr_i[g])
                q_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/mmc_irq_mask.sv
module mmc_irq_mask #(
    parameter int unsigned W   = 13,
    parameter int unsigned IN_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [IN_W-1:0] wdata_i,
    output logic [W-1:0]    q_o
);
    logic [IN_W-W-1:0] unused_hi;
    assign unused_hi = wdata_i[IN_W-1:W];

    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (wr_i)
            q_o <= wdata_i[W-1:0];
    end
endmodule

// File: rtl/mmc_irq_steer.sv
module mmc_irq_steer #(
    parameter int unsigned W    = 13,
    parameter int unsigned RX_B = 5,
    parameter int unsigned TX_B = 6
) (
    input  logic [W-1:0] req_i,
    input  logic [W-1:0] mask_i,
    input  logic         dma_i,
    output logic         cpu_o,
    output logic         rx_o,
    output logic         tx_o
);
    logic [W-1:0] eff_mask;

    always_comb begin
        eff_mask = mask_i;
        if (dma_i) begin
            eff_mask[RX_B] = 1'b1;
            eff_mask[TX_B] = 1'b1;
        end
        cpu_o = |(req_i & ~eff_mask);
        rx_o  = dma_i & req_i[RX_B];
        tx_o  = dma_i & req_i[TX_B];
    end
endmodule

// File: rtl/mmc_irq_router.sv
module mmc_irq_router
    import mmc_irq_router_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] evt_set_i,
    input  logic             mask_wr_i,
    input  logic [BUS_W-1:0] mask_wdata_i,
    input  logic             dma_mode_i,
    input  logic             clk_start_i,
    input  logic             clk_stop_i,
    input  logic             rx_port_rd_i,
    input  logic             tx_port_wr_i,
    output logic             cpu_irq_o,
    output logic             rx_dma_req_o,
    output logic             tx_dma_req_o,
    output logic [SRC_N-1:0] req_o,
    output logic [SRC_N-1:0] mask_o
);
    src_vec_t set_vec;
    src_vec_t clr_vec;

    always_comb begin
        set_vec            = evt_set_i;
        set_vec[B_CLK_OFF] = evt_set_i[B_CLK_OFF] | clk_stop_i;
        clr_vec            = '0;
        clr_vec[B_CLK_OFF] = clk_start_i;
        clr_vec[B_RX_SERV] = rx_port_rd_i;
        clr_vec[B_TX_SERV] = tx_port_wr_i;
    end

    mmc_irq_pend #(.W(SRC_N)) pend_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .q_o   (req_o)
    );

    mmc_irq_mask #(.W(SRC_N), .IN_W(BUS_W)) mask_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr_i),
        .wdata_i (mask_wdata_i),
        .q_o     (mask_o)
    );

    mmc_irq_steer #(.W(SRC_N), .RX_B(B_RX_SERV), .TX_B(B_TX_SERV)) steer_i (
        .req_i  (req_o),
        .mask_i (mask_o),
        .dma_i  (dma_mode_i),
        .cpu_o  (cpu_irq_o),
        .rx_o   (rx_dma_req_o),
        .tx_o   (tx_dma_req_o)
    );
endmodule

// File: rtl/mmc_irq_router_chk.sv
module mmc_irq_router_chk
    import mmc_irq_router_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [SRC_N-1:0] evt_set_i,
    input logic             mask_wr_i,
    input logic [BUS_W-1:0] mask_wdata_i,
    input logic             dma_mode_i,
    input logic             clk_start_i,
    input logic             clk_stop_i,
    input logic             rx_port_rd_i,
    input logic             tx_port_wr_i,
    input logic             cpu_irq_o,
    input logic             rx_dma_req_o,
    input logic             tx_dma_req_o,
    input logic [SRC_N-1:0] req_o,
    input logic [SRC_N-1:0] mask_o
);
    src_vec_t dma_blk;
    always_comb begin
        dma_blk            = '0;
        dma_blk[B_RX_SERV] = dma_mode_i;
        dma_blk[B_TX_SERV] = dma_mode_i;
    end

    // R1
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_set_i[0] |=> req_o[0]);

    // R2
    mask_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_i |=> mask_o == $past(mask_wdata_i[SRC_N-1:0]));

    // R3
    cpu_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_o & ~mask_o & ~dma_blk)) == cpu_irq_o);

    // R4
    dma_hide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode_i && (req_o & ~mask_o & ~dma_blk) == '0) |-> !cpu_irq_o);

    // R5
    dma_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req_o == (dma_mode_i && req_o[B_RX_SERV]));

    // R5
    dma_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req_o == (dma_mode_i && req_o[B_TX_SERV]));

    // R6
    clk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_i |=> req_o[B_CLK_OFF]);

    // R6
    clk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_start_i && !clk_stop_i && !evt_set_i[B_CLK_OFF]) |=> !req_o[B_CLK_OFF]);

    // R7
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_port_rd_i && !evt_set_i[B_RX_SERV]) |=> !req_o[B_RX_SERV]);

    // R7
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_port_wr_i && !evt_set_i[B_TX_SERV]) |=> !req_o[B_TX_SERV]);

    // R8
    reset_clr_chk: assert property (@(posedge clk)
        !rst_n |=> (req_o == '0 && mask_o == '0));
endmodule

bind mmc_irq_router mmc_irq_router_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_set_i    (evt_set_i),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .dma_mode_i   (dma_mode_i),
    .clk_start_i  (clk_start_i),
    .clk_stop_i   (clk_stop_i),
    .rx_port_rd_i (rx_port_rd_i),
    .tx_port_wr_i (tx_port_wr_i),
    .cpu_irq_o    (cpu_irq_o),
    .rx_dma_req_o (rx_dma_req_o),
    .tx_dma_req_o (tx_dma_req_o),
    .req_o        (req_o),
    .mask_o       (mask_o)
);

// File: tb/mmc_irq_router_tb.sv
module mmc_irq_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] evt_set_i = '0;
    logic        mask_wr_i = 1'b0;
    logic [31:0] mask_wdata_i = '0;
    logic        dma_mode_i = 1'b0;
    logic        clk_start_i = 1'b0;
    logic        clk_stop_i = 1'b0;
    logic        rx_port_rd_i = 1'b0;
    logic        tx_port_wr_i = 1'b0;
    logic        cpu_irq_o, rx_dma_req_o, tx_dma_req_o;
    logic [12:0] req_o, mask_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mmc_irq_router dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_set_i    (evt_set_i),
        .mask_wr_i    (mask_wr_i),
        .mask_wdata_i (mask_wdata_i),
        .dma_mode_i   (dma_mode_i),
        .clk_start_i  (clk_start_i),
        .clk_stop_i   (clk_stop_i),
        .rx_port_rd_i (rx_port_rd_i),
        .tx_port_wr_i (tx_port_wr_i),
        .cpu_irq_o    (cpu_irq_o),
        .rx_dma_req_o (rx_dma_req_o),
        .tx_dma_req_o (tx_dma_req_o),
        .req_o        (req_o),
        .mask_o       (mask_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Drive on a falling edge, release on the next one; the rising edge between latches.
    task automatic step();
        @(negedge clk);
        evt_set_i = '0; mask_wr_i = 1'b0; clk_start_i = 1'b0; clk_stop_i = 1'b0;
        rx_port_rd_i = 1'b0; tx_port_wr_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic write_mask(input logic [31:0] v);
        @(negedge clk); mask_wr_i = 1'b1; mask_wdata_i = v;
        step();
    endtask

    task automatic pulse_evt(input logic [12:0] v);
        @(negedge clk); evt_set_i = v;
        step();
    endtask

    task automatic t_reset();
        do_reset();
        check("R8 req", 32'(req_o), 0);
        check("R8 mask", 32'(mask_o), 0);
        check("R8 outs", {29'd0, cpu_irq_o, rx_dma_req_o, tx_dma_req_o}, 0);
    endtask

    task automatic t_sticky();
        do_reset();
        pulse_evt(13'h0001);
        check("R1 bit0 set", 32'(req_o), 32'h1);
        check("R3 irq", 32'(cpu_irq_o), 1);
        step();
        check("R1 sticky", 32'(req_o), 32'h1);
        pulse_evt(13'h1200);
        check("R1 bits 9 12", 32'(req_o), 32'h1201);
    endtask

    task automatic t_mask();
        do_reset();
        write_mask(32'hFFFF_E001);
        check("R2 low bits", 32'(mask_o), 32'h0001);
        pulse_evt(13'h0001);
        check("R3 blocked", 32'(cpu_irq_o), 0);
        pulse_evt(13'h0200);
        check("R3 unmasked", 32'(cpu_irq_o), 1);
        write_mask(32'h0000_1FFF);
        check("R3 all masked", 32'(cpu_irq_o), 0);
    endtask

    task automatic t_dma();
        do_reset();
        dma_mode_i = 1'b1;
        pulse_evt(13'h0060);
        check("R4 hidden", 32'(cpu_irq_o), 0);
        check("R5 rx", 32'(rx_dma_req_o), 1);
        check("R5 tx", 32'(tx_dma_req_o), 1);
        pulse_evt(13'h0100);
        check("R4 other bit", 32'(cpu_irq_o), 1);
        @(negedge clk); dma_mode_i = 1'b0;
        #1;
        check("R5 off", {30'd0, rx_dma_req_o, tx_dma_req_o}, 0);
        do_reset();
        pulse_evt(13'h0020);
        check("R3 rx no dma", 32'(cpu_irq_o), 1);
    endtask

    task automatic t_port_clear();
        do_reset();
        dma_mode_i = 1'b1;
        pulse_evt(13'h0060);
        @(negedge clk); rx_port_rd_i = 1'b1;
        step();
        check("R7 rx clear", 32'(req_o), 32'h0040);
        check("R7 rx dma low", 32'(rx_dma_req_o), 0);
        @(negedge clk); tx_port_wr_i = 1'b1;
        step();
        check("R7 tx clear", 32'(req_o), 32'h0);
        @(negedge clk); tx_port_wr_i = 1'b1; evt_set_i = 13'h0040;
        step();
        check("R7 tx set wins", 32'(req_o), 32'h0040);
        @(negedge clk); rx_port_rd_i = 1'b1; evt_set_i = 13'h0020;
        step();
        check("R7 rx set wins", 32'(req_o), 32'h0060);
        dma_mode_i = 1'b0;
    endtask

    task automatic t_clock();
        do_reset();
        @(negedge clk); clk_stop_i = 1'b1;
        step();
        check("R6 stop", 32'(req_o), 32'h0010);
        check("R6 irq", 32'(cpu_irq_o), 1);
        @(negedge clk); clk_start_i = 1'b1;
        step();
        check("R6 start", 32'(req_o), 32'h0);
        @(negedge clk); clk_start_i = 1'b1; clk_stop_i = 1'b1;
        step();
        check("R6 both", 32'(req_o), 32'h0010);
    endtask

    task automatic t_reset_clears();
        write_mask(32'h0000_0ABC);
        pulse_evt(13'h1FFF);
        do_reset();
        check("R8 req after", 32'(req_o), 0);
        check("R8 mask after", 32'(mask_o), 0);
        check("R8 irq after", 32'(cpu_irq_o), 0);
    endtask

    initial begin
        #50_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sticky();
        t_mask();
        t_dma();
        t_port_clear();
        t_clock();
        t_reset_clears();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule